// File: doc/BRIEF.md
# Sub-word Load/Store Lane Aligner

This combinational unit sits between a processor core and a data memory organised in whole words. It takes a byte address that has already been computed, an access size and a byte-order select. From these it produces four things: the word address, the per-lane write strobes, the store data steered onto those lanes and the load result taken out of the returned memory word. Byte and halfword loads are either sign-extended or zero-extended to full width, according to a single signedness input. Nothing else differs between the signed and unsigned load forms.

The byte-order select can change on any access. In big-endian order, byte offset 0 of a word is its most significant byte, which is lane 3 for 32-bit data. In little-endian order, offset 0 is lane 0, which holds bits 7:0. A multi-byte value always sits on contiguous lanes in natural significance order. Only its starting lane depends on the byte order. A halfword access with address bit 0 set is misaligned. A word access with either of address bits 1:0 set is also misaligned. A misaligned access raises a flag and enables no lane.

Top module: `lsu_align`

## Requirements
- R1: `word_addr` equals `addr` with its two lowest bits dropped, which is `addr[31:2]` for the default 32-bit data path.
- R2: When `misalign` is 0, `byte_en` has one bit set for a byte access (`size`=00), two bits for a halfword (`size`=01) and four bits for a word (`size`=10 or 11). Bit i marks lane i, which is data bits 8i+7:8i. A byte at offset o uses lane o in little-endian order (`big_endian`=0) and lane 3-o in big-endian order (`big_endian`=1). A halfword at offset 0 uses lanes 1:0 in little-endian order and lanes 3:2 in big-endian order. At offset 2 the two cases are reversed.
- R3: `misalign` is 1 for a halfword access with `addr[0]`=1 and for a word access with `addr[1:0]`≠0. A byte access never sets it. While `misalign` is 1, `byte_en`, `mem_wdata` and `load_data` are all zero.
- R4: A byte store places `store_data[7:0]` on the one enabled lane of `mem_wdata`. All other lanes of `mem_wdata` are zero.
- R5: A halfword store places `store_data[15:0]` on the two enabled lanes. The lower-numbered lane carries bits 7:0. The other lanes are zero.
- R6: An aligned word store drives `mem_wdata` = `store_data`.
- R7: A byte load returns the enabled lane of `mem_rdata` in `load_data[7:0]`. It is sign-extended when `sign_ext`=1 and zero-extended when `sign_ext`=0. For example, a byte of 0x90 gives 0xFFFFFF90 when sign-extended and 0x00000090 when zero-extended.
- R8: A halfword load returns the two enabled lanes in `load_data[15:0]`, with the lower-numbered lane in bits 7:0. It is sign-extended or zero-extended according to `sign_ext`.
- R9: An aligned word load returns `mem_rdata` unchanged, whatever the value of `sign_ext`.
- R10: Take memory word 0 = 0x009012A0 and word 4 = 0xFFFFFFFF. A signed byte load from address 1, followed by a byte store of the result to address 6, gives two outcomes that depend on byte order. In big-endian order the load returns 0xFFFFFF90 and word 4 becomes 0xFFFF90FF. In little-endian order the load returns 0x00000012 and word 4 becomes 0xFF12FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| big_endian | input | 1 | 1: offset 0 is the most significant lane; 0: offset 0 is lane 0 |
| addr | input | ADDR_W | Effective byte address |
| size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| sign_ext | input | 1 | 1 sign-extends sub-word loads, 0 zero-extends |
| store_data | input | DATA_W | Register value to store |
| mem_rdata | input | DATA_W | Word read from memory |
| word_addr | output | ADDR_W-2 | Word address to memory |
| byte_en | output | DATA_W/8 | Lane strobes |
| mem_wdata | output | DATA_W | Store data on lanes |
| load_data | output | DATA_W | Extended load result |
| misalign | output | 1 | Access not aligned to its size |

## Verification
The checker examines every settled input combination for five properties. A misaligned access must leave the lanes silent. A byte access must enable exactly one lane. Every lane that is not enabled must carry zero store data. The upper bits of a byte or halfword load must match the extension that `sign_ext` selects. A fully enabled word must pass through in both directions unchanged. Only the bench's reference comparison shows that the correct lane was chosen for each offset and byte order, and that the bytes sit in the correct order within a halfword. The two-step byte copy, which needs a memory model across two accesses, is likewise visible only in the bench.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_WIDE = 2'b11
   } acc_size_e;
endpackage

// File: rtl/lsu_lane_ctl.sv
// Lane window: span of the access, first lane, strobes and alignment fault.
module lsu_lane_ctl #(
   parameter int LANES = 4,
   localparam int OFF_W = $clog2(LANES),
   localparam int NB_W  = OFF_W + 1
) (
   input  logic             big_endian,
   input  logic [OFF_W-1:0] offset,
   input  logic [1:0]       size,
   output logic [1:0]       eff_size,
   output logic [OFF_W-1:0] base_lane,
   output logic [LANES-1:0] byte_en,
   output logic             misalign
);
   logic [NB_W-1:0]  nbytes;
   logic [OFF_W-1:0] span_m1;
   logic [LANES-1:0] low_mask;

   always_comb begin
      // sizes beyond the data path collapse onto a full-width access
      eff_size = (32'(size) > OFF_W) ? 2'(OFF_W) : size;
      nbytes   = NB_W'(1) << eff_size;
      span_m1  = OFF_W'(nbytes - NB_W'(1));
      misalign = |(offset & span_m1);
      low_mask = ~({LANES{1'b1}} << nbytes);
      // big-endian first lane is LANES - offset - nbytes, taken modulo LANES
      base_lane = big_endian ? (~offset - span_m1) : offset;
      byte_en   = misalign ? '0 : (low_mask << base_lane);
   end
endmodule

// File: rtl/lsu_store_pack.sv
// Moves the low-order register bytes up to the first lane and clears idle lanes.
module lsu_store_pack #(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int OFF_W = $clog2(LANES)
) (
   input  logic [DATA_W-1:0] store_data,
   input  logic [OFF_W-1:0]  base_lane,
   input  logic [LANES-1:0]  byte_en,
   output logic [DATA_W-1:0] mem_wdata
);
   logic [DATA_W-1:0] shifted;

   assign shifted = store_data << {base_lane, 3'b000};

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign mem_wdata[8*i +: 8] = byte_en[i] ? shifted[8*i +: 8] : 8'h00;
   end
endmodule

// File: rtl/lsu_load_extract.sv
// Brings the first lane down to bit 0, then extends to full width for the size.
module lsu_load_extract #(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int OFF_W = $clog2(LANES)
) (
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [OFF_W-1:0]  base_lane,
   input  logic [1:0]        eff_size,
   input  logic              sign_ext,
   input  logic              misalign,
   output logic [DATA_W-1:0] load_data
);
   logic [DATA_W-1:0] raw;
   logic [DATA_W-1:0] cand [4];

   assign raw = mem_rdata >> {base_lane, 3'b000};

   for (genvar g = 0; g < 4; g++) begin : g_ext
      localparam int W = 8 << g;
      if (W >= DATA_W) begin : g_full
         assign cand[g] = raw;
      end else begin : g_part
         assign cand[g] = {{(DATA_W-W){sign_ext & raw[W-1]}}, raw[W-1:0]};
      end
   end

   assign load_data = misalign ? '0 : cand[eff_size];
endmodule

// File: rtl/lsu_align.sv
module lsu_align #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int OFF_W = $clog2(LANES)
) (
   input  logic                    big_endian,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [1:0]              size,
   input  logic                    sign_ext,
   input  logic [DATA_W-1:0]       store_data,
   input  logic [DATA_W-1:0]       mem_rdata,
   output logic [ADDR_W-OFF_W-1:0] word_addr,
   output logic [LANES-1:0]        byte_en,
   output logic [DATA_W-1:0]       mem_wdata,
   output logic [DATA_W-1:0]       load_data,
   output logic                    misalign
);
   if (DATA_W != 32 && DATA_W != 64) begin : g_bad_width
      $error("lsu_align: DATA_W must be 32 or 64");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("lsu_align: ADDR_W too narrow");
   end

   logic [1:0]       eff_size;
   logic [OFF_W-1:0] base_lane;

   assign word_addr = addr[ADDR_W-1:OFF_W];

   lsu_lane_ctl #(.LANES(LANES)) u_ctl (
      .big_endian (big_endian),
      .offset     (addr[OFF_W-1:0]),
      .size       (size),
      .eff_size   (eff_size),
      .base_lane  (base_lane),
      .byte_en    (byte_en),
      .misalign   (misalign)
   );

   lsu_store_pack #(.DATA_W(DATA_W)) u_st (
      .store_data (store_data),
      .base_lane  (base_lane),
      .byte_en    (byte_en),
      .mem_wdata  (mem_wdata)
   );

   lsu_load_extract #(.DATA_W(DATA_W)) u_ld (
      .mem_rdata  (mem_rdata),
      .base_lane  (base_lane),
      .eff_size   (eff_size),
      .sign_ext   (sign_ext),
      .misalign   (misalign),
      .load_data  (load_data)
   );
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk #(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8
) (
   input logic [1:0]        size,
   input logic              sign_ext,
   input logic [DATA_W-1:0] store_data,
   input logic [DATA_W-1:0] mem_rdata,
   input logic [LANES-1:0]  byte_en,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [DATA_W-1:0] load_data,
   input logic              misalign
);
   always_comb begin
      if (!$isunknown({size, sign_ext, store_data, mem_rdata,
                       byte_en, mem_wdata, load_data, misalign})) begin
         a_r3_silent_when_misaligned: assert (!misalign || (byte_en == '0 && load_data == '0))
            else $error("R3: lanes active on misaligned access");
         a_r2_byte_one_lane: assert (size != 2'b00 || (!misalign && $countones(byte_en) == 1))
            else $error("R2: byte access must enable one lane");
         a_r7_byte_extension: assert (size != 2'b00 ||
               load_data[DATA_W-1:8] == {(DATA_W-8){sign_ext & load_data[7]}})
            else $error("R7: byte load extension wrong");
         a_r8_half_extension: assert (size != 2'b01 || misalign ||
               load_data[DATA_W-1:16] == {(DATA_W-16){sign_ext & load_data[15]}})
            else $error("R8: halfword load extension wrong");
         a_r9_full_passthrough: assert (!(&byte_en) ||
               (mem_wdata == store_data && load_data == mem_rdata))
            else $error("R9: full-width access altered data");
         for (int i = 0; i < LANES; i++) begin
            a_r4_idle_lane_zero: assert (byte_en[i] || mem_wdata[8*i +: 8] == 8'h00)
               else $error("R4: idle lane carries store data");
         end
      end
   end
endmodule

bind lsu_align lsu_align_chk #(.DATA_W(DATA_W)) u_chk (
   .size       (size),
   .sign_ext   (sign_ext),
   .store_data (store_data),
   .mem_rdata  (mem_rdata),
   .byte_en    (byte_en),
   .mem_wdata  (mem_wdata),
   .load_data  (load_data),
   .misalign   (misalign)
);

// File: tb/tb_lsu_align.sv
`timescale 1ns/1ps
module tb_lsu_align;
   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic        big_endian;
   logic [31:0] addr;
   logic [1:0]  size;
   logic        sign_ext;
   logic [31:0] store_data, mem_rdata;
   logic [29:0] word_addr;
   logic [3:0]  byte_en;
   logic [31:0] mem_wdata, load_data;
   logic        misalign;

   int vectors = 0;
   int fails   = 0;
   bit done    = 0;

   lsu_align dut (
      .big_endian (big_endian), .addr (addr), .size (size), .sign_ext (sign_ext),
      .store_data (store_data), .mem_rdata (mem_rdata), .word_addr (word_addr),
      .byte_en (byte_en), .mem_wdata (mem_wdata), .load_data (load_data),
      .misalign (misalign)
   );

   // behavioural reference: walk the value bytes and map each to its memory offset
   task automatic model(input bit be, input logic [31:0] a, input logic [1:0] sz,
                        input bit sx, input logic [31:0] sd, input logic [31:0] rd,
                        output logic [3:0] e_be, output logic [31:0] e_wd,
                        output logic [31:0] e_ld, output bit e_mis);
      int nb, off, o, lane;
      nb  = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
      off = int'(a[1:0]);
      e_be = '0; e_wd = '0; e_ld = '0;
      e_mis = (off % nb) != 0;
      if (!e_mis) begin
         for (int k = 0; k < nb; k++) begin
            o    = be ? (off + nb - 1 - k) : (off + k);
            lane = be ? (3 - o) : o;
            e_be[lane] = 1'b1;
            e_wd[lane*8 +: 8] = sd[k*8 +: 8];
            e_ld[k*8 +: 8]    = rd[lane*8 +: 8];
         end
         if (sx && nb < 4 && e_ld[nb*8-1])
            for (int b = nb*8; b < 32; b++) e_ld[b] = 1'b1;
      end
   endtask

   function automatic string ld_tag(input logic [1:0] sz, input bit mis);
      if (mis) return "R3";
      return (sz == 2'b00) ? "R7" : (sz == 2'b01) ? "R8" : "R9";
   endfunction

   function automatic string st_tag(input logic [1:0] sz, input bit mis);
      if (mis) return "R3";
      return (sz == 2'b00) ? "R4" : (sz == 2'b01) ? "R5" : "R6";
   endfunction

   task automatic apply(input bit be, input logic [31:0] a, input logic [1:0] sz,
                        input bit sx, input logic [31:0] sd, input logic [31:0] rd);
      logic [3:0]  e_be;
      logic [31:0] e_wd, e_ld;
      bit          e_mis;
      @(posedge clk); #2;
      big_endian = be; addr = a; size = sz; sign_ext = sx;
      store_data = sd; mem_rdata = rd;
      model(be, a, sz, sx, sd, rd, e_be, e_wd, e_ld, e_mis);
      @(negedge clk);
      vectors++;
      if (word_addr !== a[31:2]) begin
         fails++; $display("FAIL R1 word_addr actual=%h expected=%h", word_addr, a[31:2]);
      end
      if (misalign !== e_mis) begin
         fails++; $display("FAIL R3 misalign actual=%b expected=%b", misalign, e_mis);
      end
      if (byte_en !== e_be) begin
         fails++; $display("FAIL %s byte_en actual=%b expected=%b",
                           e_mis ? "R3" : "R2", byte_en, e_be);
      end
      if (mem_wdata !== e_wd) begin
         fails++; $display("FAIL %s mem_wdata actual=%h expected=%h",
                           st_tag(sz, e_mis), mem_wdata, e_wd);
      end
      if (load_data !== e_ld) begin
         fails++; $display("FAIL %s load_data actual=%h expected=%h",
                           ld_tag(sz, e_mis), load_data, e_ld);
      end
   endtask

   // R10: byte copy across two accesses through a two-word memory
   task automatic copy_scenario(input bit be, input logic [31:0] exp_ld,
                                input logic [31:0] exp_w4);
      logic [31:0] mem [2];
      logic [31:0] got;
      logic [31:0] mask;
      mem[0] = 32'h009012A0; mem[1] = 32'hFFFFFFFF;
      apply(be, 32'd1, 2'b00, 1'b1, 32'h0, mem[0]);
      got = load_data;
      vectors++;
      if (got !== exp_ld) begin
         fails++; $display("FAIL R10 loaded actual=%h expected=%h", got, exp_ld);
      end
      apply(be, 32'd6, 2'b00, 1'b1, got, mem[1]);
      mask = '0;
      for (int i = 0; i < 4; i++) if (byte_en[i]) mask[i*8 +: 8] = 8'hFF;
      mem[word_addr[0]] = (mem[word_addr[0]] & ~mask) | (mem_wdata & mask);
      vectors++;
      if (mem[1] !== exp_w4 || mem[0] !== 32'h009012A0) begin
         fails++; $display("FAIL R10 word4 actual=%h expected=%h", mem[1], exp_w4);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      big_endian = 0; addr = '0; size = '0; sign_ext = 0; store_data = '0; mem_rdata = '0;
      // idle/start-up vector, all inputs zero
      apply(1'b0, 32'h0, 2'b00, 1'b0, 32'h0, 32'h0);
      // R7: 0x90 both extensions, both orders
      apply(1'b1, 32'h1, 2'b00, 1'b1, 32'h0, 32'h009012A0);
      apply(1'b1, 32'h1, 2'b00, 1'b0, 32'h0, 32'h009012A0);
      apply(1'b0, 32'h2, 2'b00, 1'b1, 32'h0, 32'h009012A0);
      // R8 halfword sign boundary, R3 misaligned forms
      apply(1'b0, 32'h2, 2'b01, 1'b1, 32'h0, 32'h8001_7FFF);
      apply(1'b1, 32'h2, 2'b01, 1'b1, 32'h0, 32'h8001_7FFF);
      apply(1'b0, 32'h3, 2'b01, 1'b1, 32'h1234, 32'hFFFF_FFFF);
      apply(1'b1, 32'h2, 2'b10, 1'b0, 32'h1234, 32'hFFFF_FFFF);
      apply(1'b0, 32'h4, 2'b11, 1'b1, 32'hCAFE_F00D, 32'h8000_0000);
      // every order, offset, size and extension with fixed data
      for (int be = 0; be < 2; be++)
         for (int a = 0; a < 4; a++)
            for (int s = 0; s < 4; s++)
               for (int x = 0; x < 2; x++)
                  apply(be[0], 32'h1000_0000 | 32'(a), 2'(s), x[0],
                        32'hA1B2_C3D4, 32'h8F7E_6D5C);
      copy_scenario(1'b1, 32'hFFFFFF90, 32'hFFFF90FF);
      copy_scenario(1'b0, 32'h00000012, 32'hFF12FFFF);
      for (int n = 0; n < 2000; n++)
         apply(1'($urandom_range(1)), $urandom(), 2'($urandom_range(3)),
               1'($urandom_range(1)), $urandom(), $urandom());
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule